// File: doc/BRIEF.md
# Interrupt Pin Trigger and Delivery Engine

This block sits between a set of interrupt input pins and the logic that forwards messages to processors. Every pin owns a routing entry that holds a mask bit, an input polarity, a trigger style (edge or level), a vector, a destination, a destination mode and a delivery mode. The engine samples the pins each cycle, keeps one request bit per pin, decides which assertions deserve a new delivery, and presents deliveries one at a time on a valid/ready output. It does not arbitrate between processors.

Edge pins deliver once for each new assertion. Level pins deliver and then stay quiet until the receiving side signals completion by presenting the entry's vector on the end-of-interrupt input. Assertions that cannot start a new delivery are not lost silently: they raise a one-cycle bit on the coalesced output. Rewriting a routing entry also unblocks a level pin. Pin 0 is special: its deliveries always go in physical destination mode to the boot processor, whatever its entry holds.

Top module: `irq_trig_engine`

## Requirements
- R1: After reset every routing entry is masked, `dlv_valid` is 0 and `coal` is all zeros, so pins that assert before configuration produce neither a delivery nor a coalesced bit.
- R2: A pin's effective level is `pin_in[i]` XOR its polarity bit, and its request bit takes that effective level at each clock edge; a pin with polarity 1 therefore asserts when its raw input goes to 0.
- R3: An unmasked edge pin (level bit 0) gets one delivery each time its request bit goes from 0 to 1; if the rising edge is sampled at edge k and the output is free, `dlv_valid` is 1 after edge k+1. A new rising edge that arrives while that pin's delivery is still queued and not yet loaded to the output sets `coal[i]` for the cycle after the sampling edge.
- R4: When a delivery of a level pin (level bit 1) is accepted (`dlv_valid` and `dlv_ready` both 1), the pin becomes remote-pending; a new assertion of that pin while remote-pending produces no delivery and sets `coal[i]` for one cycle.
- R5: An end-of-interrupt with `eoi_vector` equal to the vector of a level entry clears that entry's remote-pending state, and if the pin is still asserted and unmasked it is delivered again; a non-matching vector changes nothing.
- R6: Writing a routing entry clears that pin's remote-pending state; if the new entry is level-triggered and unmasked and the pin is asserted, a new delivery is queued.
- R7: An assertion of a masked pin (mask bit 1) produces neither a delivery nor a coalesced bit.
- R8: A delivery from pin 0 always carries `dlv_dest` equal to the BOOT_DEST parameter and `dlv_dest_mode` 0 (physical); vector, delivery mode and trigger come from its entry.
- R9: When several pins are queued, the lowest-numbered one is loaded first; the others remain queued and follow in ascending order.
- R10: While `dlv_valid` is 1 and `dlv_ready` is 0 all delivery fields stay unchanged; on an accepting edge the next queued delivery, if any, is loaded in the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NPIN | Raw interrupt pin levels |
| cfg_we | input | 1 | Routing entry write strobe |
| cfg_pin | input | PIN_W | Index of the entry written |
| cfg_mask | input | 1 | New mask bit (1 = masked) |
| cfg_pol | input | 1 | New polarity bit (1 = active low) |
| cfg_level | input | 1 | New trigger style (1 = level, 0 = edge) |
| cfg_vector | input | VEC_W | New vector |
| cfg_dest | input | DEST_W | New destination |
| cfg_dest_mode | input | 1 | New destination mode (0 = physical, 1 = logical) |
| cfg_dlv_mode | input | DLM_W | New delivery mode code |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | VEC_W | Vector being completed |
| dlv_valid | output | 1 | Delivery request present |
| dlv_ready | input | 1 | Delivery accepted when high with dlv_valid |
| dlv_pin | output | PIN_W | Pin that the delivery came from |
| dlv_vector | output | VEC_W | Vector of the delivery |
| dlv_dest | output | DEST_W | Destination of the delivery |
| dlv_dest_mode | output | 1 | Destination mode of the delivery |
| dlv_mode | output | DLM_W | Delivery mode code |
| dlv_level | output | 1 | Trigger style of the delivery (1 = level) |
| coal | output | NPIN | One-cycle bit per pin for a coalesced assertion |

## Verification
The bench drives a level pin through acceptance, repeated assertions and completions, where a design that forgot the remote-pending block would deliver a storm of duplicates, and one that ignored the vector compare would release the pin on the wrong completion. It stalls the output while an edge pin pulses twice, catching a design that drops or double-counts the second pulse instead of coalescing it, and that lets the held fields drift. It queues two pins in one cycle to expose a wrong priority order, asserts a masked pin to catch spurious coalesced bits, and inspects a pin 0 delivery whose entry asks for logical mode, which a design without the override would forward unchanged.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;
  parameter int VEC_W  = 8;
  parameter int DEST_W = 8;
  parameter int DLM_W  = 3;

  typedef struct packed {
    logic             mask;
    logic             pol;
    logic             lvl;
    logic [VEC_W-1:0]  vec;
    logic [DEST_W-1:0] dest;
    logic             dmode;
    logic [DLM_W-1:0]  dlm;
  } route_t;

  localparam route_t ROUTE_RESET = '{mask: 1'b1, pol: 1'b0, lvl: 1'b0,
                                      vec: '0, dest: '0, dmode: 1'b0, dlm: '0};
endpackage

// File: rtl/irq_route_table.sv
module irq_route_table
  import irq_trig_pkg::*;
#(
  parameter int NPIN  = 8,
  parameter int PIN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [PIN_W-1:0] wr_idx,
  input  route_t           wr_ent,
  output route_t           ent [NPIN]
);
  // Entries are read in parallel by every pin cell, so they live in flops.
  for (genvar i = 0; i < NPIN; i++) begin : g_ent
    route_t ent_q;
    always_ff @(posedge clk) begin
      if (rst) ent_q <= ROUTE_RESET;
      else if (wr_en && wr_idx == PIN_W'(i)) ent_q <= wr_ent;
    end
    assign ent[i] = ent_q;

    // R1: right after reset every entry is masked
    p_reset_masked_r1: assert property (@(posedge clk) rst |=> ent_q.mask);
  end
endmodule

// File: rtl/irq_pin_cell.sv
module irq_pin_cell
  import irq_trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             raw,
  input  route_t           ent,
  input  logic             wr_hit,
  input  route_t           wr_ent,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  input  logic             grant,
  input  logic             acc_lvl,
  output logic             svc_q,
  output logic             coal_q
);
  logic irr_q, rem_q;
  logic eff, rise, ask, blocked, eoi_hit, resvc_eoi, resvc_wr;

  always_comb begin
    eff       = raw ^ ent.pol;
    rise      = eff & ~irr_q;
    ask       = rise & ~ent.mask;
    blocked   = svc_q | (ent.lvl & rem_q);
    eoi_hit   = eoi_valid && ent.lvl && (ent.vec == eoi_vector);
    resvc_eoi = eoi_hit & ~ent.mask & irr_q;
    resvc_wr  = wr_hit & wr_ent.lvl & ~wr_ent.mask & irr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q  <= 1'b0;
      rem_q  <= 1'b0;
      svc_q  <= 1'b0;
      coal_q <= 1'b0;
    end else begin
      irr_q  <= eff;
      coal_q <= ask & blocked;
      svc_q  <= (svc_q & ~grant) | (ask & ~blocked) | resvc_eoi | resvc_wr;
      if (acc_lvl)               rem_q <= 1'b1;
      else if (eoi_hit || wr_hit) rem_q <= 1'b0;
    end
  end

  // R4: an accepted level delivery leaves the pin remote-pending
  p_remote_on_accept_r4: assert property (@(posedge clk) disable iff (rst)
    acc_lvl |=> rem_q);
  // R4: a level assertion while remote-pending is reported, not queued
  p_level_blocked_r4: assert property (@(posedge clk) disable iff (rst)
    (ask && ent.lvl && rem_q && !grant && !resvc_eoi && !resvc_wr && !svc_q) |=> (coal_q && !svc_q));
  // R3: a queued delivery stays queued until granted
  p_svc_kept_r3: assert property (@(posedge clk) disable iff (rst)
    (svc_q && !grant) |=> svc_q);
endmodule

// File: rtl/irq_pick_low.sv
module irq_pick_low #(
  parameter int NPIN  = 8,
  parameter int PIN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPIN-1:0]  req,
  output logic [NPIN-1:0]  gnt,
  output logic [PIN_W-1:0] idx,
  output logic             any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < NPIN; i++) begin
      if (req[i] && !any) begin
        gnt[i] = 1'b1;
        idx    = PIN_W'(i);
        any    = 1'b1;
      end
    end
  end

  // R9: grant is a single requested bit with nothing lower requesting
  p_grant_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt) && ((gnt & ~req) == '0));
  p_lowest_first_r9: assert property (@(posedge clk) disable iff (rst)
    any |-> (((gnt - 1'b1) & req) == '0));
endmodule

// File: rtl/irq_trig_engine.sv
module irq_trig_engine
  import irq_trig_pkg::*;
#(
  parameter int               NPIN      = 8,
  parameter logic [DEST_W-1:0] BOOT_DEST = '0,
  localparam int              PIN_W     = (NPIN > 1) ? $clog2(NPIN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPIN-1:0]   pin_in,
  input  logic              cfg_we,
  input  logic [PIN_W-1:0]  cfg_pin,
  input  logic              cfg_mask,
  input  logic              cfg_pol,
  input  logic              cfg_level,
  input  logic [VEC_W-1:0]  cfg_vector,
  input  logic [DEST_W-1:0] cfg_dest,
  input  logic              cfg_dest_mode,
  input  logic [DLM_W-1:0]  cfg_dlv_mode,
  input  logic              eoi_valid,
  input  logic [VEC_W-1:0]  eoi_vector,
  output logic              dlv_valid,
  input  logic              dlv_ready,
  output logic [PIN_W-1:0]  dlv_pin,
  output logic [VEC_W-1:0]  dlv_vector,
  output logic [DEST_W-1:0] dlv_dest,
  output logic              dlv_dest_mode,
  output logic [DLM_W-1:0]  dlv_mode,
  output logic              dlv_level,
  output logic [NPIN-1:0]   coal
);
  route_t            wr_ent;
  route_t            ent [NPIN];
  logic [NPIN-1:0]   svc, pick, grant;
  logic [PIN_W-1:0]  pick_idx;
  logic              pick_any, load, accept;

  assign wr_ent = '{mask: cfg_mask, pol: cfg_pol, lvl: cfg_level, vec: cfg_vector,
                    dest: cfg_dest, dmode: cfg_dest_mode, dlm: cfg_dlv_mode};

  irq_route_table #(.NPIN(NPIN), .PIN_W(PIN_W)) u_table (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_idx(cfg_pin), .wr_ent(wr_ent), .ent(ent)
  );

  assign accept = dlv_valid & dlv_ready;
  assign load   = pick_any & (~dlv_valid | dlv_ready);
  assign grant  = load ? pick : '0;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    irq_pin_cell u_cell (
      .clk(clk), .rst(rst), .raw(pin_in[i]), .ent(ent[i]),
      .wr_hit(cfg_we && cfg_pin == PIN_W'(i)), .wr_ent(wr_ent),
      .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
      .grant(grant[i]),
      .acc_lvl(accept && dlv_level && dlv_pin == PIN_W'(i)),
      .svc_q(svc[i]), .coal_q(coal[i])
    );
  end

  irq_pick_low #(.NPIN(NPIN), .PIN_W(PIN_W)) u_pick (
    .clk(clk), .rst(rst), .req(svc), .gnt(pick), .idx(pick_idx), .any(pick_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_valid     <= 1'b0;
      dlv_pin       <= '0;
      dlv_vector    <= '0;
      dlv_dest      <= '0;
      dlv_dest_mode <= 1'b0;
      dlv_mode      <= '0;
      dlv_level     <= 1'b0;
    end else if (load) begin
      dlv_valid  <= 1'b1;
      dlv_pin    <= pick_idx;
      dlv_vector <= ent[pick_idx].vec;
      dlv_mode   <= ent[pick_idx].dlm;
      dlv_level  <= ent[pick_idx].lvl;
      if (pick_idx == '0) begin
        dlv_dest      <= BOOT_DEST;
        dlv_dest_mode <= 1'b0;
      end else begin
        dlv_dest      <= ent[pick_idx].dest;
        dlv_dest_mode <= ent[pick_idx].dmode;
      end
    end else if (accept) begin
      dlv_valid <= 1'b0;
    end
  end

  // R10: a stalled delivery keeps every field
  p_hold_stall_r10: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_pin) && $stable(dlv_vector)
      && $stable(dlv_dest) && $stable(dlv_dest_mode) && $stable(dlv_mode) && $stable(dlv_level)));
  // R8: pin 0 goes physical to the boot destination
  p_pin0_phys_r8: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && dlv_pin == '0) |-> (!dlv_dest_mode && dlv_dest == BOOT_DEST));
  // R1: nothing is presented in the cycle after reset
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (!dlv_valid && coal == '0));
endmodule

// File: tb/irq_trig_engine_test.sv
`timescale 1ns/1ps
module irq_trig_engine_test;
  import irq_trig_pkg::*;
  localparam int NPIN = 8;
  localparam int PIN_W = 3;
  localparam int NROW = 30;

  logic clk = 1'b0;
  logic rst;
  logic [NPIN-1:0] pin_in;
  logic cfg_we, cfg_mask, cfg_pol, cfg_level, cfg_dest_mode;
  logic [PIN_W-1:0] cfg_pin;
  logic [VEC_W-1:0] cfg_vector, eoi_vector, dlv_vector;
  logic [DEST_W-1:0] cfg_dest, dlv_dest;
  logic [DLM_W-1:0] cfg_dlv_mode, dlv_mode;
  logic eoi_valid, dlv_valid, dlv_ready, dlv_dest_mode, dlv_level;
  logic [PIN_W-1:0] dlv_pin;
  logic [NPIN-1:0] coal;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  irq_trig_engine #(.NPIN(NPIN), .BOOT_DEST(8'h00)) uut (
    .clk(clk), .rst(rst), .pin_in(pin_in),
    .cfg_we(cfg_we), .cfg_pin(cfg_pin), .cfg_mask(cfg_mask), .cfg_pol(cfg_pol),
    .cfg_level(cfg_level), .cfg_vector(cfg_vector), .cfg_dest(cfg_dest),
    .cfg_dest_mode(cfg_dest_mode), .cfg_dlv_mode(cfg_dlv_mode),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_pin(dlv_pin),
    .dlv_vector(dlv_vector), .dlv_dest(dlv_dest), .dlv_dest_mode(dlv_dest_mode),
    .dlv_mode(dlv_mode), .dlv_level(dlv_level), .coal(coal)
  );

  // Row: pins[29:22] rdy[21] eoi[20] evec[19:12] exp_valid[11] exp_pin[10:8] exp_coal[7:0]
  // Entries: pin0 edge vec20, pin1 level vec31, pin2 edge active-low vec42,
  // pin3 masked, pin4 level vec64. Raw idle value is 8'h04.
  localparam logic [29:0] TBL [NROW] = '{
    {8'h04,1'b1,1'b0,8'h00,1'b0,3'd0,8'h00}, // 0  idle (R2)
    {8'h05,1'b1,1'b0,8'h00,1'b0,3'd0,8'h00}, // 1  pin0 rises (R3)
    {8'h05,1'b1,1'b0,8'h00,1'b1,3'd0,8'h00}, // 2  pin0 presented (R3)
    {8'h05,1'b1,1'b0,8'h00,1'b0,3'd0,8'h00}, // 3  accepted, held high: no repeat (R3)
    {8'h04,1'b1,1'b0,8'h00,1'b0,3'd0,8'h00}, // 4
    {8'h06,1'b1,1'b0,8'h00,1'b0,3'd0,8'h00}, // 5  pin1 level rises (R4)
    {8'h06,1'b1,1'b0,8'h00,1'b1,3'd1,8'h00}, // 6  pin1 presented
    {8'h06,1'b1,1'b0,8'h00,1'b0,3'd0,8'h00}, // 7  accepted -> remote-pending
    {8'h04,1'b1,1'b0,8'h00,1'b0,3'd0,8'h00}, // 8
    {8'h06,1'b1,1'b0,8'h00,1'b0,3'd0,8'h02}, // 9  blocked -> coalesced (R4)
    {8'h04,1'b1,1'b0,8'h00,1'b0,3'd0,8'h00}, // 10
    {8'h06,1'b1,1'b0,8'h00,1'b0,3'd0,8'h02}, // 11 blocked again (R4)
    {8'h06,1'b1,1'b1,8'h31,1'b0,3'd0,8'h00}, // 12 completion, pin still high (R5)
    {8'h06,1'b1,1'b0,8'h00,1'b1,3'd1,8'h00}, // 13 re-delivered (R5)
    {8'h06,1'b1,1'b0,8'h00,1'b0,3'd0,8'h00}, // 14
    {8'h00,1'b1,1'b0,8'h00,1'b0,3'd0,8'h00}, // 15 pin2 raw low = asserted (R2)
    {8'h00,1'b0,1'b0,8'h00,1'b1,3'd2,8'h00}, // 16 presented, stalled (R10)
    {8'h04,1'b0,1'b0,8'h00,1'b1,3'd2,8'h00}, // 17
    {8'h00,1'b0,1'b0,8'h00,1'b1,3'd2,8'h00}, // 18 second edge queued (R3)
    {8'h04,1'b0,1'b0,8'h00,1'b1,3'd2,8'h00}, // 19
    {8'h00,1'b0,1'b0,8'h00,1'b1,3'd2,8'h04}, // 20 third edge while queued (R3)
    {8'h04,1'b1,1'b0,8'h00,1'b1,3'd2,8'h00}, // 21 accept + reload same edge (R10)
    {8'h04,1'b1,1'b0,8'h00,1'b0,3'd0,8'h00}, // 22
    {8'h15,1'b1,1'b0,8'h00,1'b0,3'd0,8'h00}, // 23 pins 0 and 4 together (R9)
    {8'h15,1'b1,1'b0,8'h00,1'b1,3'd0,8'h00}, // 24 pin0 first
    {8'h15,1'b1,1'b0,8'h00,1'b1,3'd4,8'h00}, // 25 then pin4
    {8'h15,1'b1,1'b0,8'h00,1'b0,3'd0,8'h00}, // 26
    {8'h1D,1'b1,1'b0,8'h00,1'b0,3'd0,8'h00}, // 27 masked pin3 rises (R7)
    {8'h1D,1'b1,1'b0,8'h00,1'b0,3'd0,8'h00}, // 28
    {8'h04,1'b1,1'b0,8'h00,1'b0,3'd0,8'h00}  // 29
  };

  function automatic string row_req(input int r);
    if (r <= 4)  return "R3";
    if (r <= 11) return "R4";
    if (r <= 14) return "R5";
    if (r <= 22) return "R10";
    if (r <= 26) return "R9";
    return "R7";
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [NPIN-1:0] p, input logic rdy,
                      input logic ev, input logic [VEC_W-1:0] evec);
    pin_in = p; dlv_ready = rdy; eoi_valid = ev; eoi_vector = evec;
    @(posedge clk); #1;
  endtask

  task automatic wr(input int idx, input logic m, input logic pl, input logic lv,
                    input logic [7:0] v, input logic [7:0] d, input logic dm,
                    input logic [2:0] dl);
    cfg_we = 1'b1; cfg_pin = PIN_W'(idx); cfg_mask = m; cfg_pol = pl; cfg_level = lv;
    cfg_vector = v; cfg_dest = d; cfg_dest_mode = dm; cfg_dlv_mode = dl;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL R1 watchdog expired: actual 0x0 expected 0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; pin_in = 8'h04; cfg_we = 1'b0; cfg_pin = '0; cfg_mask = 1'b1;
    cfg_pol = 1'b0; cfg_level = 1'b0; cfg_vector = '0; cfg_dest = '0;
    cfg_dest_mode = 1'b0; cfg_dlv_mode = '0; eoi_valid = 1'b0; eoi_vector = '0;
    dlv_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk(dlv_valid == 1'b0, "R1", "valid after reset", 32'(dlv_valid), 0);
    chk(coal == '0, "R1", "coal after reset", 32'(coal), 0);
    step(8'h05, 1'b1, 1'b0, 8'h00);
    step(8'h05, 1'b1, 1'b0, 8'h00);
    step(8'h04, 1'b1, 1'b0, 8'h00);
    chk(dlv_valid == 1'b0 && coal == '0, "R1", "masked-by-reset pins quiet",
        32'({dlv_valid, coal}), 0);

    wr(0, 1'b0, 1'b0, 1'b0, 8'h20, 8'h05, 1'b1, 3'd1);
    wr(1, 1'b0, 1'b0, 1'b1, 8'h31, 8'h02, 1'b0, 3'd0);
    wr(2, 1'b0, 1'b1, 1'b0, 8'h42, 8'h03, 1'b0, 3'd0);
    wr(3, 1'b1, 1'b0, 1'b0, 8'h53, 8'h04, 1'b0, 3'd0);
    wr(4, 1'b0, 1'b0, 1'b1, 8'h64, 8'h06, 1'b0, 3'd0);
    step(8'h04, 1'b1, 1'b0, 8'h00);

    for (int r = 0; r < NROW; r++) begin
      step(TBL[r][29:22], TBL[r][21], TBL[r][20], TBL[r][19:12]);
      chk(dlv_valid == TBL[r][11], row_req(r), $sformatf("row %0d valid", r),
          32'(dlv_valid), 32'(TBL[r][11]));
      if (TBL[r][11])
        chk(dlv_pin == TBL[r][10:8], row_req(r), $sformatf("row %0d pin", r),
            32'(dlv_pin), 32'(TBL[r][10:8]));
      chk(coal == TBL[r][7:0], row_req(r), $sformatf("row %0d coal", r),
          32'(coal), 32'(TBL[r][7:0]));
    end

    // R4 / R6: pin4 is remote-pending; a new assertion coalesces, a rewrite releases it
    step(8'h14, 1'b1, 1'b0, 8'h00);
    chk(coal == 8'h10, "R4", "pin4 coalesced", 32'(coal), 32'h10);
    wr(4, 1'b0, 1'b0, 1'b1, 8'h64, 8'h09, 1'b1, 3'd0);
    step(8'h14, 1'b0, 1'b0, 8'h00);
    chk(dlv_valid && dlv_pin == 3'd4, "R6", "rewrite re-delivers pin4",
        32'({dlv_valid, dlv_pin}), 32'({1'b1, 3'd4}));
    chk(dlv_vector == 8'h64 && dlv_dest == 8'h09 && dlv_dest_mode && dlv_level, "R6",
        "pin4 fields", 32'({dlv_vector, dlv_dest, dlv_dest_mode, dlv_level}),
        32'({8'h64, 8'h09, 1'b1, 1'b1}));
    step(8'h14, 1'b1, 1'b0, 8'h00);

    // R5: a completion with another vector leaves the pin blocked
    step(8'h14, 1'b1, 1'b1, 8'h99);
    step(8'h04, 1'b1, 1'b0, 8'h00);
    step(8'h14, 1'b1, 1'b0, 8'h00);
    chk(coal == 8'h10 && !dlv_valid, "R5", "non-matching completion ignored",
        32'({dlv_valid, coal}), 32'h10);
    step(8'h14, 1'b1, 1'b1, 8'h64);
    step(8'h14, 1'b0, 1'b0, 8'h00);
    chk(dlv_valid && dlv_pin == 3'd4, "R5", "matching completion re-delivers",
        32'({dlv_valid, dlv_pin}), 32'({1'b1, 3'd4}));
    step(8'h04, 1'b1, 1'b0, 8'h00);

    // R8: pin0 entry asks for logical mode to dest 5
    step(8'h05, 1'b0, 1'b0, 8'h00);
    step(8'h05, 1'b0, 1'b0, 8'h00);
    chk(dlv_valid && dlv_pin == 3'd0, "R8", "pin0 presented",
        32'({dlv_valid, dlv_pin}), 32'({1'b1, 3'd0}));
    chk(dlv_dest == 8'h00 && dlv_dest_mode == 1'b0, "R8", "pin0 forced physical/boot",
        32'({dlv_dest, dlv_dest_mode}), 0);
    chk(dlv_vector == 8'h20 && dlv_mode == 3'd1 && !dlv_level, "R8", "pin0 entry fields",
        32'({dlv_vector, dlv_mode, dlv_level}), 32'({8'h20, 3'd1, 1'b0}));
    step(8'h04, 1'b1, 1'b0, 8'h00);
    chk(!dlv_valid, "R10", "accepted pin0 drops valid", 32'(dlv_valid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule